// File: doc/BRIEF.md
# Instruction Prefetch Queue Sequencer

This block is the fetch and execute front end of a small 8-bit accumulator processor. It keeps a two-byte queue that holds the current opcode and the byte after it. It drives a single memory read port that can start one read per bus cycle. Read data comes back one cycle after the read is issued, and the block latches it at the end of that cycle. It is used in the following cycle at the earliest.

Every instruction starts in the same condition: the opcode and the next byte sit in the queue, and the read of the third byte is still in flight. The last cycles of each instruction are program fetches that restore this condition for the next instruction. Because of this, each opcode takes a fixed number of bus cycles whatever ran before it.

Only three instructions are handled: load accumulator with the byte that follows, load accumulator from an 8-bit direct address, and no-operation. The block reports its accumulator and program counter. It also reports, every cycle, whether the bus cycle is a program fetch, a data read or a free cycle.

Top module: `pfq_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the cycle is free (code 0), the read strobe is low and the accumulator reads 0x00. The next three cycles are program fetches from the reset vector, the reset vector plus one and the reset vector plus two. Execution of the first instruction starts in the cycle after those three.
- R2: The read strobe is high in every program fetch and data read cycle and low in every free cycle. Read data on the data input is taken in the cycle after the strobe.
- R3: A program fetch drives the program counter on the address bus. The program counter then advances by one, modulo 2^16. Other cycles leave it unchanged.
- R4: Opcode 0xA6 takes exactly two cycles, both program fetches. The accumulator takes the byte that follows the opcode, visible from the second cycle.
- R5: Opcode 0xB6 takes exactly three cycles in the order data read, fetch, fetch. The data read drives address 0x00 concatenated with the byte that follows the opcode. The returned byte is in the accumulator from the third cycle on.
- R6: Opcode 0x9D takes exactly one program fetch cycle and leaves the accumulator unchanged.
- R7: Any opcode other than 0xA6, 0xB6 and 0x9D behaves exactly like 0x9D.
- R8: The cycle pattern of each instruction depends only on its opcode, not on the instructions before it.
- R9: The cycle code output is 0 for a free cycle, 1 for a program fetch and 2 for a data read. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_vec | input | 16 | Address of the first program byte, sampled during reset |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| acc | output | 8 | Accumulator |
| pc | output | 16 | Address of the next program byte to fetch |
| cyc_kind | output | 2 | Cycle code: 0 free, 1 program fetch, 2 data read |

## Verification
The hardest case to reach is a program whose fetches cross the top of the address space. In that case the queue contents and the data read address must stay correct while the program counter wraps from 0xFFFF to 0x0000. The bench runs the same program trace again from reset vector 0xFFFE, so the wrap falls during the start-up fetches. A reset is also raised in the middle of a direct load's data read, to show the block restarts cleanly. The trace mixes load, no-operation and undefined opcodes in different orders, so that each instruction's cycle pattern is seen after a different predecessor.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [1:0] {
        CYC_FREE = 2'd0,
        CYC_PROG = 2'd1,
        CYC_READ = 2'd2
    } cyc_kind_e;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_LDI = 2'd1,
        OP_LDD = 2'd2
    } op_cls_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_BOOT0 = 3'd1,
        PH_BOOT1 = 3'd2,
        PH_BOOT2 = 3'd3,
        PH_EXEC  = 3'd4
    } phase_e;

endpackage

// File: rtl/pfq_decode.sv
module pfq_decode
    import pfq_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  OPC_LDI = 8'hA6,
    parameter logic [7:0]  OPC_LDD = 8'hB6,
    parameter logic [7:0]  OPC_NOP = 8'h9D
) (
    input  logic [DATA_W-1:0] opcode,
    output op_cls_e           cls
);
    // Unknown codes fall through to no-operation so the queue never stalls.
    always_comb begin
        if (opcode == DATA_W'(OPC_LDI))      cls = OP_LDI;
        else if (opcode == DATA_W'(OPC_LDD)) cls = OP_LDD;
        else if (opcode == DATA_W'(OPC_NOP)) cls = OP_NOP;
        else                                 cls = OP_NOP;
    end
endmodule

// File: rtl/pfq_bus_drive.sv
module pfq_bus_drive
    import pfq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  cyc_kind_e         kind,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] oper,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd
);
    localparam int PAD_W = ADDR_W - DATA_W;

    always_comb begin
        mem_rd = (kind != CYC_FREE);
        if (kind == CYC_READ) mem_addr = {{PAD_W{1'b0}}, oper};
        else                  mem_addr = pc;
    end
endmodule

// File: rtl/pfq_seq.sv
module pfq_seq
    import pfq_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  OPC_LDI = 8'hA6,
    parameter logic [7:0]  OPC_LDD = 8'hB6,
    parameter logic [7:0]  OPC_NOP = 8'h9D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rst_vec,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] pc,
    output logic [1:0]        cyc_kind
);
    localparam int STEP_W = 2;

    typedef struct packed {
        phase_e             ph;
        logic [STEP_W-1:0]  step;
        op_cls_e            op;
        logic [DATA_W-1:0]  q0;
        logic [DATA_W-1:0]  q1;
        logic [DATA_W-1:0]  acc;
        logic [ADDR_W-1:0]  pc;
    } seq_st_t;

    seq_st_t   st_q, st_d;
    op_cls_e   dec_cls;
    op_cls_e   cur_op;
    cyc_kind_e kind;

    pfq_decode #(
        .DATA_W  (DATA_W),
        .OPC_LDI (OPC_LDI),
        .OPC_LDD (OPC_LDD),
        .OPC_NOP (OPC_NOP)
    ) u_dec (
        .opcode (st_q.q0),
        .cls    (dec_cls)
    );

    pfq_bus_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .kind     (kind),
        .pc       (st_q.pc),
        .oper     (st_q.q1),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd)
    );

    // The opcode is decoded in the first step only; the queue head is
    // overwritten during the step, so later steps use the held class.
    always_comb begin
        st_d   = st_q;
        kind   = CYC_FREE;
        cur_op = (st_q.step == '0) ? dec_cls : st_q.op;

        unique case (st_q.ph)
            PH_IDLE: begin
                kind    = CYC_FREE;
                st_d.ph = PH_BOOT0;
            end
            PH_BOOT0: begin
                kind    = CYC_PROG;
                st_d.ph = PH_BOOT1;
            end
            PH_BOOT1: begin
                kind    = CYC_PROG;
                st_d.q0 = mem_rdata;
                st_d.ph = PH_BOOT2;
            end
            PH_BOOT2: begin
                kind      = CYC_PROG;
                st_d.q1   = mem_rdata;
                st_d.ph   = PH_EXEC;
                st_d.step = '0;
            end
            default: begin
                unique case (cur_op)
                    OP_LDI: begin
                        kind = CYC_PROG;
                        if (st_q.step == '0) begin
                            st_d.acc  = st_q.q1;
                            st_d.q0   = mem_rdata;
                            st_d.op   = OP_LDI;
                            st_d.step = STEP_W'(1);
                        end else begin
                            st_d.q1   = mem_rdata;
                            st_d.step = '0;
                        end
                    end
                    OP_LDD: begin
                        if (st_q.step == '0) begin
                            kind      = CYC_READ;
                            st_d.q0   = mem_rdata;
                            st_d.op   = OP_LDD;
                            st_d.step = STEP_W'(1);
                        end else if (st_q.step == STEP_W'(1)) begin
                            kind      = CYC_PROG;
                            st_d.acc  = mem_rdata;
                            st_d.step = STEP_W'(2);
                        end else begin
                            kind      = CYC_PROG;
                            st_d.q1   = mem_rdata;
                            st_d.step = '0;
                        end
                    end
                    default: begin
                        kind      = CYC_PROG;
                        st_d.q0   = st_q.q1;
                        st_d.q1   = mem_rdata;
                        st_d.op   = OP_NOP;
                        st_d.step = '0;
                    end
                endcase
            end
        endcase

        if (kind == CYC_PROG) st_d.pc = st_q.pc + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.step <= '0;
            st_q.op   <= OP_NOP;
            st_q.q0   <= '0;
            st_q.q1   <= '0;
            st_q.acc  <= '0;
            st_q.pc   <= rst_vec;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc      = st_q.acc;
    assign pc       = st_q.pc;
    assign cyc_kind = kind;

endmodule

// File: rtl/pfq_seq_chk.sv
module pfq_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] pc,
    input logic [1:0]        cyc_kind
);
    a_r1_first_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cyc_kind == 2'd0));

    a_r2_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind != 2'd0) |-> mem_rd);

    a_r2_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 2'd0) |-> !mem_rd);

    a_r3_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 2'd1) |=> (pc == ADDR_W'($past(pc) + ADDR_W'(1))));

    a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind != 2'd1) |=> $stable(pc));

    a_r5_read_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 2'd2) |=> (cyc_kind == 2'd1));

    a_r5_read_low_page: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 2'd2) |-> (mem_addr[ADDR_W-1:DATA_W] == '0));

    a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_kind != 2'd3);

endmodule

bind pfq_seq pfq_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .pc       (pc),
    .cyc_kind (cyc_kind)
);

// File: tb/tb_pfq_seq.sv
module tb_pfq_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rst_vec = 16'h1000;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  acc;
    logic [15:0] pc;
    logic [1:0]  cyc_kind;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pfq_seq dut (
        .clk(clk), .rst_n(rst_n), .rst_vec(rst_vec),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .acc(acc), .pc(pc), .cyc_kind(cyc_kind)
    );

    // Program: A6 11 | B6 40 | 9D | A6 22 | 00 (undefined) | B6 41 | A6 33 | 9D...
    localparam logic [7:0] PROG [16] = '{
        8'hA6, 8'h11, 8'hB6, 8'h40, 8'h9D, 8'hA6, 8'h22, 8'h00,
        8'hB6, 8'h41, 8'hA6, 8'h33, 8'h9D, 8'h9D, 8'h9D, 8'h9D };

    // {code, addr (offset from reset vector for fetches, absolute for reads), acc seen}
    localparam int NCYC = 20;
    localparam logic [25:0] TRACE [NCYC] = '{
        {2'd0, 16'h0000, 8'h00}, {2'd1, 16'h0000, 8'h00},
        {2'd1, 16'h0001, 8'h00}, {2'd1, 16'h0002, 8'h00},
        {2'd1, 16'h0003, 8'h00}, {2'd1, 16'h0004, 8'h11},
        {2'd2, 16'h0040, 8'h11}, {2'd1, 16'h0005, 8'h11},
        {2'd1, 16'h0006, 8'h83}, {2'd1, 16'h0007, 8'h83},
        {2'd1, 16'h0008, 8'h83}, {2'd1, 16'h0009, 8'h22},
        {2'd1, 16'h000A, 8'h22}, {2'd2, 16'h0041, 8'h22},
        {2'd1, 16'h000B, 8'h22}, {2'd1, 16'h000C, 8'h82},
        {2'd1, 16'h000D, 8'h82}, {2'd1, 16'h000E, 8'h33},
        {2'd1, 16'h000F, 8'h33}, {2'd1, 16'h0010, 8'h33} };

    function automatic logic [7:0] memval(input logic [15:0] a);
        logic [15:0] off;
        off = a - rst_vec;
        if (off < 16'd16) return PROG[off[3:0]];
        return a[7:0] ^ 8'hC3;
    endfunction

    always @(posedge clk) mem_rdata <= mem_rd ? memval(mem_addr) : 8'h00;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reset_check(input logic [15:0] vec);
        rst_n   = 1'b0;
        rst_vec = vec;
        repeat (2) @(negedge clk);
        chk("R1 reset code", 32'(cyc_kind), 32'd0);
        chk("R1 reset strobe", 32'(mem_rd), 32'd0);
        chk("R1 reset acc", 32'(acc), 32'h00);
        chk("R1 reset pc", 32'(pc), 32'(vec));
    endtask

    task automatic run_trace(input int ncyc);
        rst_n = 1'b1;
        #1;
        for (int k = 0; k < ncyc; k++) begin
            logic [1:0]  code;
            logic [15:0] ad;
            logic [7:0]  ac;
            if (k > 0) @(negedge clk);
            {code, ad, ac} = TRACE[k];
            chk(k < 4 ? "R1 boot code" : "R8 R9 cycle code", 32'(cyc_kind), 32'(code));
            chk("R2 strobe", 32'(mem_rd), 32'(code != 2'd0));
            chk("R4 R5 R6 R7 acc", 32'(acc), 32'(ac));
            if (code == 2'd1) begin
                chk("R3 fetch addr", 32'(mem_addr), 32'(16'(rst_vec + ad)));
                chk("R3 pc", 32'(pc), 32'(16'(rst_vec + ad)));
            end else if (code == 2'd2) begin
                chk("R5 read addr", 32'(mem_addr), 32'(ad));
            end
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        reset_check(16'h1000);
        run_trace(NCYC);
        // Program counter wraps during start-up fetches
        @(negedge clk);
        reset_check(16'hFFFE);
        run_trace(NCYC);
        // Reset raised in the middle of a direct load's data read
        @(negedge clk);
        reset_check(16'h1000);
        run_trace(7);
        reset_check(16'h2000);
        run_trace(NCYC);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule